// File: doc/BRIEF.md
# System Bus Single-Write Sequencer

This block sits on the processor side of a multiplexed address/data system bus and turns single write requests into bus cycles for an external agent. A request (address plus data) enters through a valid/ready port and is held in a one-entry buffer. When the agent's active-low write-ready line permits, the block drives an address cycle and then a data cycle. On both of these cycles it asserts an active-low valid strobe and puts a command code on the command bus. On every other cycle the strobe is released and a no-operation command is driven.

Two write protocols are selectable at a mode input. In the fixed-length protocol every write takes four bus cycles: the address, the data and two padding cycles. The padding gives the agent time to withdraw write-ready before the next write can begin. In the replay protocol there is no padding. Instead, the agent must also hold write-ready low during the address cycle. If it does not, the address cycle is discarded and the same write is offered again later, and a wrapping counter records each discarded address cycle. A completion pulse follows the data cycle of every write that goes through.

Top module: `sbw_write_seq`

## Requirements
- R1: After reset the valid strobe is high, the command is no-operation (code 0), request-ready is high, the completion pulse is low and the replay counter is 0. The write-ready history resets to "not ready", so a pending write waits until write-ready has been seen low.
- R2: An address cycle is driven only if write-ready was low on the bus cycle two cycles before it.
- R3: An address cycle drives the valid strobe low, command code 1 and the pending write's address on the shared bus.
- R4: An address cycle that is not discarded is followed immediately by the data cycle: valid strobe low, command code 2 and the write's data on the bus. A data cycle never appears in any other position.
- R5: With mode code 0, 2 or 3 (fixed-length; code 2 is the reserved pipelined setting), write-ready during the address cycle is ignored. The data cycle is followed by two cycles with the valid strobe high and command 0. When the next request is already waiting, its address cycle comes three cycles after the previous data cycle.
- R6: With mode code 1 (replay), an address cycle during which write-ready is high is discarded. No data cycle follows it, the write stays pending with the same address, and the replay counter increases by one.
- R7: In replay mode there are no padding cycles. When the next request is already waiting and write-ready stays low, its address cycle comes two cycles after the previous data cycle.
- R8: The completion pulse is high for exactly the one cycle after each data cycle, and at no other time.
- R9: Request-ready is high when no write is pending or during the data cycle of the pending write, and it is low during an address cycle. Writes reach the bus in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Protocol select: 1 replay, any other value fixed-length |
| req_valid | input | 1 | Write request offered |
| req_addr | input | DW | Write address |
| req_data | input | DW | Write data |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| wr_rdy_n | input | 1 | Agent write-ready, active low |
| bus_ad | output | DW | Multiplexed address/data bus |
| bus_cmd | output | 3 | Command code: 0 no-op, 1 write address, 2 last data |
| valid_out_n | output | 1 | Bus cycle valid strobe, active low |
| wr_done | output | 1 | One-cycle pulse after a completed data cycle |
| reissue_cnt | output | CW | Count of discarded address cycles, wrapping |

## Verification
On every cycle the assertions check these properties: the two-cycle write-ready lead before each address cycle, that a kept address cycle is followed by its data cycle, the replay decision and counter step, the two padding cycles in the fixed-length protocol, the timing of the completion pulse, and that the buffer is busy during an address cycle. Only the bench scenarios can show the rest. These are the address and data values against the accepted order, the replay of the same address after a discard, the different restart spacing of the two protocols, that the reserved mode code behaves as fixed-length, and that no write starts before write-ready has first been seen.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_PAD1,
        ST_PAD2
    } seq_state_e;

    localparam logic [2:0] CMD_NOP   = 3'd0;
    localparam logic [2:0] CMD_WRITE = 3'd1;
    localparam logic [2:0] CMD_LAST  = 3'd2;

    localparam logic [1:0] MODE_REISSUE = 2'b01;

endpackage

// File: rtl/sbw_rdy_hist.sv
module sbw_rdy_hist #(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_rdy_n,
    output logic lead_ok
);
    localparam int HW = LEAD - 1;

    logic [HW-1:0] hist_d, hist_q;

    generate
        if (HW == 1) begin : g_single
            always_comb hist_d = wr_rdy_n;
        end else begin : g_shift
            always_comb hist_d = {hist_q[HW-2:0], wr_rdy_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= hist_d;
    end

    assign lead_ok = !hist_q[HW-1];

endmodule

// File: rtl/sbw_req_buf.sv
module sbw_req_buf #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          release_i,
    output logic          req_ready,
    output logic          pend_o,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          pend;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    assign req_ready = !buf_q.pend || release_i;

    always_comb begin
        buf_d = buf_q;
        if (release_i) buf_d.pend = 1'b0;
        if (req_valid && req_ready) begin
            buf_d.pend = 1'b1;
            buf_d.addr = req_addr;
            buf_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign pend_o = buf_q.pend;
    assign addr_o = buf_q.addr;
    assign data_o = buf_q.data;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_q.pend && !release_i) |=> (buf_q.pend && $stable(buf_q.addr)));

endmodule

// File: rtl/sbw_seq.sv
module sbw_seq
    import sbw_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reissue_i,
    input  logic          pend_i,
    input  logic          lead_ok_i,
    input  logic          wr_rdy_n,
    output seq_state_e    state_o,
    output logic          release_o,
    output logic          wr_done,
    output logic [CW-1:0] reissue_cnt
);
    typedef struct packed {
        seq_state_e    state;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_ok;

    assign start_ok = pend_i && lead_ok_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: if (start_ok) seq_d.state = ST_ADDR;
            ST_ADDR: begin
                if (reissue_i && wr_rdy_n) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = seq_q.cnt + 1'b1;
                end else begin
                    seq_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                seq_d.done  = 1'b1;
                seq_d.state = reissue_i ? ST_IDLE : ST_PAD1;
            end
            ST_PAD1: seq_d.state = ST_PAD2;
            ST_PAD2: seq_d.state = start_ok ? ST_ADDR : ST_IDLE;
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, done: 1'b0, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign state_o     = seq_q.state;
    assign release_o   = (seq_q.state == ST_DATA);
    assign wr_done     = seq_q.done;
    assign reissue_cnt = seq_q.cnt;

    p_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_ADDR) |-> !$past(wr_rdy_n, 2));

    p_start_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_ADDR) |-> pend_i);

endmodule

// File: rtl/sbw_write_seq.sv
module sbw_write_seq
    import sbw_pkg::*;
#(
    parameter int DW   = 64,
    parameter int CW   = 8,
    parameter int LEAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    input  logic          wr_rdy_n,
    output logic [DW-1:0] bus_ad,
    output logic [2:0]    bus_cmd,
    output logic          valid_out_n,
    output logic          wr_done,
    output logic [CW-1:0] reissue_cnt
);
    logic          reissue, lead_ok, pend, release_w;
    logic [DW-1:0] addr_w, data_w;
    seq_state_e    state_w;

    assign reissue = (mode_sel == MODE_REISSUE);

    sbw_rdy_hist #(.LEAD(LEAD)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rdy_n (wr_rdy_n),
        .lead_ok  (lead_ok)
    );

    sbw_req_buf #(.DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .release_i (release_w),
        .req_ready (req_ready),
        .pend_o    (pend),
        .addr_o    (addr_w),
        .data_o    (data_w)
    );

    sbw_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reissue_i   (reissue),
        .pend_i      (pend),
        .lead_ok_i   (lead_ok),
        .wr_rdy_n    (wr_rdy_n),
        .state_o     (state_w),
        .release_o   (release_w),
        .wr_done     (wr_done),
        .reissue_cnt (reissue_cnt)
    );

    always_comb begin
        bus_ad      = '0;
        bus_cmd     = CMD_NOP;
        valid_out_n = 1'b1;
        case (state_w)
            ST_ADDR: begin
                bus_ad      = addr_w;
                bus_cmd     = CMD_WRITE;
                valid_out_n = 1'b0;
            end
            ST_DATA: begin
                bus_ad      = data_w;
                bus_cmd     = CMD_LAST;
                valid_out_n = 1'b0;
            end
            default: ;
        endcase
    end

    p_addr_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out_n && bus_cmd == CMD_WRITE && (!reissue || !wr_rdy_n))
        |=> (!valid_out_n && bus_cmd == CMD_LAST));

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out_n && bus_cmd == CMD_WRITE && reissue && wr_rdy_n)
        |=> (valid_out_n && reissue_cnt == CW'($past(reissue_cnt) + 1'b1)));

    p_pad1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_LAST && !reissue) |=> (valid_out_n && bus_cmd == CMD_NOP));

    p_pad2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_cmd == CMD_LAST && !reissue, 2) |-> (valid_out_n && bus_cmd == CMD_NOP));

    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out_n && bus_cmd == CMD_LAST) |=> wr_done);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out_n && bus_cmd == CMD_WRITE) |-> !req_ready);

endmodule

// File: tb/sbw_write_seq_bench.sv
module sbw_write_seq_bench;
    localparam int DW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic          req_valid = 1'b0;
    logic [DW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready;
    logic          wr_rdy_n = 1'b1;
    logic [DW-1:0] bus_ad;
    logic [2:0]    bus_cmd;
    logic          valid_out_n;
    logic          wr_done;
    logic [CW-1:0] reissue_cnt;

    sbw_write_seq #(.DW(DW), .CW(CW)) u_sbw_write_seq (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .wr_rdy_n(wr_rdy_n), .bus_ad(bus_ad),
        .bus_cmd(bus_cmd), .valid_out_n(valid_out_n), .wr_done(wr_done),
        .reissue_cnt(reissue_cnt)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] addr_q[$];
    logic [DW-1:0] data_q[$];
    int rdy_pat = 0, drv_cyc = 0;
    int rej = 0, cyc = 0, last_data = -1;
    bit b2b = 1'b0, exp_data = 1'b0, exp_done = 1'b0;
    int pad_left = 0;
    logic h1 = 1'b1, h2 = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // write-ready pattern driver, away from the clock edge
    always @(posedge clk) begin
        #1;
        drv_cyc++;
        case (rdy_pat)
            1:       wr_rdy_n = 1'b0;
            2:       wr_rdy_n = (drv_cyc % 6 != 0);
            default: wr_rdy_n = 1'b1;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            bit is_a, is_d, rs, nxt_data, nxt_done;
            is_a = !valid_out_n && bus_cmd == 3'd1;
            is_d = !valid_out_n && bus_cmd == 3'd2;
            rs = (mode_sel == 2'b01);
            nxt_data = 1'b0;
            nxt_done = 1'b0;
            if (pad_left > 0) begin
                chk(valid_out_n && bus_cmd == 3'd0, "R5 pad cycle", {60'd0, valid_out_n, bus_cmd}, 64'h8);
                pad_left--;
            end
            if (exp_data) begin
                chk(is_d, "R4 data cycle after address", {61'd0, bus_cmd}, 64'd2);
                if (data_q.size() > 0) begin
                    chk(bus_ad == data_q[0], "R4 data value", bus_ad, data_q[0]);
                    void'(addr_q.pop_front());
                    void'(data_q.pop_front());
                end else chk(1'b0, "R9 data with empty queue", 64'd0, 64'd1);
                chk(req_ready, "R9 ready during data cycle", {63'd0, req_ready}, 64'd1);
                nxt_done = 1'b1;
                pad_left = rs ? 0 : 2;
                last_data = cyc;
            end else if (is_d) begin
                chk(1'b0, "R4 R6 unexpected data cycle", bus_ad, 64'd0);
            end
            if (is_a) begin
                chk(h2 == 1'b0, "R2 lead ready two cycles before", {63'd0, h2}, 64'd0);
                chk(addr_q.size() > 0 && bus_ad == addr_q[0], "R3 address value", bus_ad,
                    addr_q.size() > 0 ? addr_q[0] : 64'd0);
                chk(!req_ready, "R9 busy in address cycle", {63'd0, req_ready}, 64'd0);
                if (b2b && last_data >= 0)
                    chk(cyc - last_data == (rs ? 2 : 3), rs ? "R7 restart gap" : "R5 restart gap",
                        64'(cyc - last_data), rs ? 64'd2 : 64'd3);
                if (rs && wr_rdy_n) rej++;
                else nxt_data = 1'b1;
            end
            if (!is_a && !is_d && pad_left == 0)
                chk(valid_out_n && bus_cmd == 3'd0, "R5 idle bus", {60'd0, valid_out_n, bus_cmd}, 64'h8);
            if (exp_done) chk(wr_done, "R8 done after data", {63'd0, wr_done}, 64'd1);
            else chk(!wr_done, "R8 no stray done", {63'd0, wr_done}, 64'd0);
            exp_done = nxt_done;
            exp_data = nxt_data;
            h2 = h1;
            h1 = wr_rdy_n;
            cyc++;
        end
    end

    task automatic push_wr(input logic [DW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_data = d;
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
        end
        addr_q.push_back(a);
        data_q.push_back(d);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (addr_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        chk(addr_q.size() == 0, req, 64'(addr_q.size()), 64'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        chk(valid_out_n && bus_cmd == 3'd0, "R1 reset bus idle", {60'd0, valid_out_n, bus_cmd}, 64'h8);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
        chk(!wr_done, "R1 done low after reset", {63'd0, wr_done}, 64'd0);
        chk(reissue_cnt == 0, "R1 counter zero", 64'(reissue_cnt), 64'd0);

        // R1: write waits while ready has never been seen low
        mode_sel = 2'b00;
        push_wr(64'h1000, 64'hA0A0_0001);
        repeat (12) @(negedge clk);
        chk(addr_q.size() == 1, "R1 no write before ready", 64'(addr_q.size()), 64'd1);
        chk(!req_ready, "R9 buffer full", {63'd0, req_ready}, 64'd0);

        // R5: fixed-length mode, back-to-back
        b2b = 1'b1; last_data = -1; rdy_pat = 1;
        push_wr(64'h1008, 64'hA0A0_0002);
        push_wr(64'h1010, 64'hA0A0_0003);
        drain("R5 compat writes complete");
        b2b = 1'b0;

        // R5: ready high in address cycle ignored
        rdy_pat = 2;
        push_wr(64'h2000, 64'hB0B0_0001);
        push_wr(64'h2008, 64'hB0B0_0002);
        drain("R5 compat ignores ready in address cycle");
        chk(reissue_cnt == 0, "R5 no replays in compat", 64'(reissue_cnt), 64'd0);

        // R7: replay mode back-to-back with ready held low
        rdy_pat = 1;
        repeat (4) @(posedge clk);
        #1 mode_sel = 2'b01;
        b2b = 1'b1; last_data = -1;
        push_wr(64'h3000, 64'hC0C0_0001);
        push_wr(64'h3008, 64'hC0C0_0002);
        push_wr(64'h3010, 64'hC0C0_0003);
        drain("R7 replay writes complete");
        b2b = 1'b0;
        chk(reissue_cnt == 0, "R7 no replays when ready held", 64'(reissue_cnt), 64'd0);

        // R6: rejected address cycles, then acceptance
        rdy_pat = 2;
        push_wr(64'h4000, 64'hD0D0_0001);
        repeat (24) @(negedge clk);
        chk(rej > 0, "R6 address cycles discarded", 64'(rej), 64'd1);
        chk(addr_q.size() == 1, "R6 write still pending", 64'(addr_q.size()), 64'd1);
        rdy_pat = 1;
        drain("R6 replayed write completes");
        chk(reissue_cnt == CW'(rej), "R6 replay counter", 64'(reissue_cnt), 64'(rej));

        // R5: reserved pipelined code behaves as fixed-length
        repeat (4) @(posedge clk);
        #1 mode_sel = 2'b10;
        b2b = 1'b1; last_data = -1;
        push_wr(64'h5000, 64'hE0E0_0001);
        push_wr(64'h5008, 64'hE0E0_0002);
        drain("R5 reserved code writes complete");
        b2b = 1'b0;

        finish_run();
    end

endmodule